// File: doc/BRIEF.md
# SCL Rate and Setup Timer

This block turns a system clock into the SCL waveform timing of an I2C master in standard and fast mode. A single 16-bit baud count sets the unit length of one clock phase. The speed-mode code decides how a full period splits into a low half and a high half. In standard mode the two halves are equal. In fast mode the low half is twice the high half, so a period is three units long.

When a slave stretches the clock by holding SCL low during the high phase, the timer freezes. After the slave lets go, the timer waits for a programmable setup count so that data can settle before it continues with the high phase. The protocol engine next to this block uses `rise_tick` and `fall_tick` to place its data and sampling steps.

All pins are plain control and status signals. No data stream crosses this block, so there is no valid/ready handshake.

Top module: `scl_rate_timer`

## Requirements
- R1: When `pe_en` is 0, `scl_o` is 1 (line released) from the next cycle and neither tick pulses. On the first clock edge that sees the block running, `scl_o` goes to 0 and a low phase starts.
- R2: In standard mode (`speed_mode` = 2'b00) with count N, `scl_o` stays 0 for N cycles and then 1 for N cycles.
- R3: In fast mode (`speed_mode` = 2'b01) with count N, `scl_o` stays 0 for 2N cycles and then 1 for N cycles.
- R4: A `baud_count` of 0 behaves like a count of 1.
- R5: During the high phase, while `scl_in` is 0, the high-phase count does not advance and `scl_o` stays 1.
- R6: After `scl_in` returns to 1 following a stretch, the high phase stays frozen for exactly `setup_count` more cycles (0 means no delay). A high phase with no stretch is never delayed by `setup_count`.
- R7: `rise_tick` is 1 for exactly the first cycle of each high phase, and `fall_tick` is 1 for exactly the first cycle of each low phase. The two are never 1 together.
- R8: The block runs only when `op_mode` = 2'b01 (master). Any other code holds the block as if it were disabled.
- R9: The speed codes 2'b10 and 2'b11 fall back to the standard-mode split.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pe_en | input | 1 | Peripheral enable |
| op_mode | input | 2 | Operating mode; 2'b01 = master |
| speed_mode | input | 2 | 00 standard, 01 fast, others standard |
| baud_count | input | 16 | Phase unit length in clock cycles |
| setup_count | input | 16 | Setup delay after a stretch release |
| scl_in | input | 1 | Sampled SCL line level |
| scl_o | output | 1 | 0 = drive SCL low, 1 = release |
| rise_tick | output | 1 | First cycle of a high phase |
| fall_tick | output | 1 | First cycle of a low phase |

## Verification
Each output is registered. The first low cycle is seen one edge after the enable is applied, and each phase boundary takes effect on the edge after the last counted cycle. The bench drives inputs on falling edges and samples on falling edges. This lets it count phase widths directly as numbers of consecutive samples, with each tick tested in the first sample of its phase. Stretch release is driven before the edge that ends cycle H+1 of the high phase, which keeps the expected high width at N+H+S.

// File: rtl/scl_timer_pkg.sv
package scl_timer_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'b00,
    PH_LOW  = 2'b01,
    PH_HIGH = 2'b10
  } scl_phase_e;

  localparam logic [1:0] OPM_MASTER = 2'b01;
  localparam logic [1:0] SPD_FAST   = 2'b01;
endpackage

// File: rtl/scl_phase_len.sv
module scl_phase_len #(
  parameter int CW        = 16,
  parameter int FAST_MULT = 2
) (
  input  logic [CW-1:0] baud,
  input  logic [1:0]    speed,
  output logic [CW:0]   low_len,
  output logic [CW:0]   high_len
);
  import scl_timer_pkg::*;
  localparam int LW = CW + 1;

  logic [LW-1:0] unit;

  always_comb begin
    unit = (baud == '0) ? LW'(1) : {1'b0, baud};
    high_len = unit;
    if (speed == SPD_FAST) low_len = LW'(unit * LW'(FAST_MULT));
    else                   low_len = unit;
  end
endmodule

// File: rtl/scl_setup_guard.sv
module scl_setup_guard #(
  parameter int SW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          in_high,
  input  logic          scl_in,
  input  logic [SW-1:0] setup_len,
  output logic          advance
);
  logic          stretched;
  logic [SW-1:0] wait_cnt;
  logic          wait_done;

  assign wait_done = (wait_cnt == setup_len);
  assign advance   = in_high && scl_in && (!stretched || wait_done);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stretched <= 1'b0;
      wait_cnt  <= '0;
    end else if (!run) begin
      stretched <= 1'b0;
      wait_cnt  <= '0;
    end else if (in_high && !scl_in) begin
      stretched <= 1'b1;
      wait_cnt  <= '0;
    end else if (stretched && scl_in) begin
      if (wait_done) begin
        stretched <= 1'b0;
        wait_cnt  <= '0;
      end else begin
        wait_cnt <= wait_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/scl_phase_ctr.sv
module scl_phase_ctr #(
  parameter int LW = 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [LW-1:0] low_len,
  input  logic [LW-1:0] high_len,
  input  logic          advance,
  output logic          in_high,
  output logic          scl_o,
  output logic          rise_tick,
  output logic          fall_tick
);
  import scl_timer_pkg::*;

  scl_phase_e    phase;
  logic [LW-1:0] cnt;

  assign in_high = (phase == PH_HIGH);
  assign scl_o   = (phase != PH_LOW);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      cnt       <= '0;
      rise_tick <= 1'b0;
      fall_tick <= 1'b0;
    end else begin
      rise_tick <= 1'b0;
      fall_tick <= 1'b0;
      if (!run) begin
        phase <= PH_IDLE;
        cnt   <= '0;
      end else begin
        unique case (phase)
          PH_IDLE: begin
            phase     <= PH_LOW;
            cnt       <= '0;
            fall_tick <= 1'b1;
          end
          PH_LOW: begin
            if (cnt >= low_len - 1'b1) begin
              phase     <= PH_HIGH;
              cnt       <= '0;
              rise_tick <= 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          PH_HIGH: begin
            if (advance) begin
              if (cnt >= high_len - 1'b1) begin
                phase     <= PH_LOW;
                cnt       <= '0;
                fall_tick <= 1'b1;
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
          end
          default: phase <= PH_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/scl_rate_timer.sv
module scl_rate_timer #(
  parameter int BAUD_W  = 16,
  parameter int SETUP_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pe_en,
  input  logic [1:0]         op_mode,
  input  logic [1:0]         speed_mode,
  input  logic [BAUD_W-1:0]  baud_count,
  input  logic [SETUP_W-1:0] setup_count,
  input  logic               scl_in,
  output logic               scl_o,
  output logic               rise_tick,
  output logic               fall_tick
);
  import scl_timer_pkg::*;
  localparam int LW = BAUD_W + 1;

  logic          run;
  logic [LW-1:0] low_len;
  logic [LW-1:0] high_len;
  logic          advance;
  logic          in_high;

  assign run = pe_en && (op_mode == OPM_MASTER);

  scl_phase_len #(.CW(BAUD_W), .FAST_MULT(2)) len_i (
    .baud     (baud_count),
    .speed    (speed_mode),
    .low_len  (low_len),
    .high_len (high_len)
  );

  scl_setup_guard #(.SW(SETUP_W)) guard_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .in_high   (in_high),
    .scl_in    (scl_in),
    .setup_len (setup_count),
    .advance   (advance)
  );

  scl_phase_ctr #(.LW(LW)) ctr_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .low_len   (low_len),
    .high_len  (high_len),
    .advance   (advance),
    .in_high   (in_high),
    .scl_o     (scl_o),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick)
  );
endmodule

// File: rtl/scl_rate_timer_chk.sv
module scl_rate_timer_chk #(
  parameter int BAUD_W  = 16,
  parameter int SETUP_W = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               pe_en,
  input logic [1:0]         op_mode,
  input logic [1:0]         speed_mode,
  input logic [BAUD_W-1:0]  baud_count,
  input logic [SETUP_W-1:0] setup_count,
  input logic               scl_in,
  input logic               scl_o,
  input logic               rise_tick,
  input logic               fall_tick
);
  logic run_c;
  assign run_c = pe_en && (op_mode == 2'b01);

  // R1
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pe_en |=> (scl_o && !rise_tick && !fall_tick));

  // R8
  non_master_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_mode != 2'b01) |=> (scl_o && !fall_tick));

  // R5
  stretch_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_c && $past(run_c) && scl_o && !scl_in) |=> scl_o);

  // R7
  rise_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_tick |-> (scl_o && !$past(scl_o)));

  // R7
  fall_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall_tick |-> (!scl_o && $past(scl_o)));

  // R7
  tick_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rise_tick, fall_tick}));
endmodule

bind scl_rate_timer scl_rate_timer_chk #(.BAUD_W(BAUD_W), .SETUP_W(SETUP_W)) chk_i (.*);

// File: tb/scl_rate_timer_tb_top.sv
module scl_rate_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pe_en = 1'b0;
  logic [1:0]  op_mode = 2'b01;
  logic [1:0]  speed_mode = 2'b00;
  logic [15:0] baud_count = 16'd1;
  logic [15:0] setup_count = 16'd0;
  logic        slave_hold = 1'b0;
  logic        scl_in;
  logic        scl_o, rise_tick, fall_tick;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;
  assign scl_in = scl_o & ~slave_hold;

  scl_rate_timer dut_i (
    .clk(clk), .rst_n(rst_n), .pe_en(pe_en), .op_mode(op_mode),
    .speed_mode(speed_mode), .baud_count(baud_count), .setup_count(setup_count),
    .scl_in(scl_in), .scl_o(scl_o), .rise_tick(rise_tick), .fall_tick(fall_tick)
  );

  localparam int NV = 10;
  localparam int V_SPD  [NV] = '{0, 1, 0, 1, 0, 1, 0, 1, 0, 2};
  localparam int V_BAUD [NV] = '{3, 3, 0, 0, 4, 2, 5, 1, 2, 3};
  localparam int V_SET  [NV] = '{0, 0, 0, 0, 2, 5, 0, 3, 0, 0};
  localparam int V_HOLD [NV] = '{0, 0, 0, 0, 3, 1, 2, 0, 20, 0};
  localparam int V_LO   [NV] = '{3, 6, 1, 2, 4, 4, 5, 2, 2, 3};
  localparam int V_HI   [NV] = '{3, 3, 1, 1, 9, 8, 7, 1, 22, 3};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_vec(input int i);
    int lo, hi;
    bit ft, rt;
    string lreq, hreq;
    pe_en = 1'b0;
    @(negedge clk); @(negedge clk);
    speed_mode  = 2'(V_SPD[i]);
    baud_count  = 16'(V_BAUD[i]);
    setup_count = 16'(V_SET[i]);
    slave_hold  = (V_HOLD[i] > 0);
    op_mode     = 2'b01;
    pe_en       = 1'b1;
    @(negedge clk);
    ft = fall_tick;
    lo = 0;
    while (!scl_o && lo < 1000) begin lo++; @(negedge clk); end
    rt = rise_tick;
    hi = 0;
    while (scl_o && hi < 1000) begin
      hi++;
      if (hi == V_HOLD[i] + 1) slave_hold = 1'b0;
      @(negedge clk);
    end
    lreq = (V_BAUD[i] == 0) ? "R4 low width" :
           (V_SPD[i] == 1)  ? "R3 low width" :
           (V_SPD[i] == 2)  ? "R9 low width" : "R2 low width";
    hreq = (V_HOLD[i] > 0)  ? "R5 R6 high width" :
           (V_SET[i] > 0)   ? "R6 high width no stretch" :
           (V_BAUD[i] == 0) ? "R4 high width" : "R2 R3 high width";
    check(lo == V_LO[i], lreq, lo, V_LO[i]);
    check(hi == V_HI[i], hreq, hi, V_HI[i]);
    check(ft == 1'b1, "R7 fall_tick first low", int'(ft), 1);
    check(rt == 1'b1, "R7 rise_tick first high", int'(rt), 1);
    pe_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(scl_o == 1'b1, "R1 reset scl_o", int'(scl_o), 1);
    check({rise_tick, fall_tick} == 2'b00, "R1 reset ticks", int'({rise_tick, fall_tick}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) run_vec(i);

    // R8 non-master mode holds the line released
    begin
      int lows;
      lows = 0;
      @(negedge clk);
      speed_mode = 2'b00; baud_count = 16'd2; setup_count = 16'd0; slave_hold = 1'b0;
      op_mode = 2'b10; pe_en = 1'b1;
      for (int k = 0; k < 8; k++) begin
        @(negedge clk);
        if (!scl_o || fall_tick) lows++;
      end
      check(lows == 0, "R8 op_mode not master", lows, 0);
      pe_en = 1'b0; op_mode = 2'b01;
    end

    // R1 disable in the middle of a low phase
    begin
      int lows;
      lows = 0;
      @(negedge clk); @(negedge clk);
      baud_count = 16'd10; pe_en = 1'b1;
      repeat (3) @(negedge clk);
      check(scl_o == 1'b0, "R1 running low phase", int'(scl_o), 0);
      pe_en = 1'b0;
      for (int k = 0; k < 6; k++) begin
        @(negedge clk);
        if (!scl_o) lows++;
      end
      check(lows == 0, "R1 disable releases line", lows, 0);
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule